// File: doc/BRIEF.md
# 64b/66b Self-Synchronizing Payload Scrambler

This block sits between the block encoder and the serdes gearbox of a BASE-R style link. It holds two independent lanes. The transmit lane scrambles the 64-bit payload of each 66-bit block. The receive lane descrambles the payload of each block taken from the line. Both lanes use a 58-bit self-synchronizing shift register. Each payload bit is combined with two taps of that register. The register then moves one place toward its top bit, and a feedback bit enters at the bottom. The transmit lane feeds back the bit it has just produced. The receive lane feeds back the bit it has just received. Because of this, a receiver falls into step with the transmitter once it has seen 58 line bits, whatever it held before.

Payload bits are handled from bit 0 up to bit 63 inside a block, and the register carries over from one block to the next. All 64 bits of a block are processed in one clock, so the block works on whole blocks whatever width the serdes word has. The 2-bit sync header is never scrambled. It is delayed by the same one register stage as the payload, so it stays with its block. A shared bypass input makes both lanes pass payload through unchanged and freezes both registers.

Each lane decides its action every cycle and names it as one of three states. ACT_IDLE applies when no block is presented: the output valid drops and the register holds. ACT_PASS applies when a block arrives with bypass set: the payload is copied and the register holds. ACT_MIX applies when a block arrives with bypass clear: the payload is scrambled or descrambled and the register advances. The lane moves to whichever state its inputs select in that cycle, with no sequencing of its own.

Top module: `scr66_duplex`

## Requirements
- R1: While reset is high, both lanes drive output valid low, header 0 and data 0. Both shift registers load all ones, so the first block after reset is processed from an all-ones register.
- R2: In the transmit lane, output bit i equals input bit i XOR register bit 38 XOR register bit 57. Bits are taken in order i = 0..63. After each bit the register shifts left by one, and the new output bit enters register bit 0.
- R3: In the receive lane, the same XOR with taps 38 and 57 applies, but the received input bit enters register bit 0. Descrambling a transmit-lane output stream therefore returns the original payload.
- R4: The register state carries from one valid block to the next. A payload sequence yields the output of one continuous 64-bit-per-block bit stream.
- R5: The 2-bit header appears on the output unchanged, in the same cycle as the payload of its block.
- R6: While bypass is high, a valid block's payload appears on the output unchanged and neither register changes. The next scrambled block continues from the register as it was before bypass.
- R7: A cycle with input valid low does not change the register.
- R8: Output valid, header and data appear exactly one clock after the block is presented.
- R9: A receive lane that starts from a mismatched register recovers the correct payload from the second line block it receives from a running transmitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | Pass payload through unchanged and freeze both registers |
| tx_in_valid | input | 1 | Transmit block present |
| tx_in_hdr | input | 2 | Transmit sync header |
| tx_in_data | input | 64 | Transmit payload, bit 0 processed first |
| tx_out_valid | output | 1 | Scrambled block present |
| tx_out_hdr | output | 2 | Header delayed with its payload |
| tx_out_data | output | 64 | Scrambled payload |
| rx_in_valid | input | 1 | Received block present |
| rx_in_hdr | input | 2 | Received sync header |
| rx_in_data | input | 64 | Received line payload |
| rx_out_valid | output | 1 | Descrambled block present |
| rx_out_hdr | output | 2 | Header delayed with its payload |
| rx_out_data | output | 64 | Descrambled payload |

## Verification
The bench builds the block with its defaults: a 64-bit payload, a 2-bit header, a 58-bit register and taps at 38 and 57. With these values, a bit-serial model written in the bench can predict every scrambled word exactly. Running line words back through the receive lane shows the round trip returns the original payload. The 58-bit register is shorter than one block, so a mismatched receiver has to settle within a single block. The bench can therefore observe resynchronization on the block right after the first one.

// File: rtl/scr66_pkg.sv
`timescale 1ns/1ps
package scr66_pkg;

    // Which bit a lane feeds back into its shift register
    typedef enum logic {
        DIR_TX = 1'b0,   // feed back the produced (line) bit
        DIR_RX = 1'b1    // feed back the received (line) bit
    } lane_dir_e;

    // Per-cycle action of a lane
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_PASS = 2'd1,
        ACT_MIX  = 2'd2
    } lane_act_e;

endpackage

// File: rtl/scr66_mixer.sv
`timescale 1ns/1ps
// Combinational 64-step self-synchronizing mix of one block payload.
module scr66_mixer
    import scr66_pkg::*;
#(
    parameter int        DATA_W  = 64,
    parameter int        STATE_W = 58,
    parameter int        TAP_LO  = 38,
    parameter int        TAP_HI  = 57,
    parameter lane_dir_e DIR     = DIR_TX
) (
    input  logic [STATE_W-1:0] st_in,
    input  logic [DATA_W-1:0]  din,
    output logic [STATE_W-1:0] st_out,
    output logic [DATA_W-1:0]  dout
);

    always_comb begin
        logic [STATE_W-1:0] s;
        logic               o;
        logic               fb;
        s    = st_in;
        dout = '0;
        for (int i = 0; i < DATA_W; i++) begin
            o       = din[i] ^ s[TAP_LO] ^ s[TAP_HI];
            dout[i] = o;
            fb      = (DIR == DIR_TX) ? o : din[i];
            s       = {s[STATE_W-2:0], fb};
        end
        st_out = s;
    end

endmodule

// File: rtl/scr66_lane.sv
`timescale 1ns/1ps
// One direction: action select, state register, registered outputs.
module scr66_lane
    import scr66_pkg::*;
#(
    parameter int        DATA_W  = 64,
    parameter int        HDR_W   = 2,
    parameter int        STATE_W = 58,
    parameter int        TAP_LO  = 38,
    parameter int        TAP_HI  = 57,
    parameter lane_dir_e DIR     = DIR_TX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic              in_valid,
    input  logic [HDR_W-1:0]  in_hdr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [HDR_W-1:0]  out_hdr,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [STATE_W-1:0] SEED = '1;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_mix;
    logic [DATA_W-1:0]  data_mix;
    lane_act_e          act;

    logic               out_valid_q;
    logic [HDR_W-1:0]   out_hdr_q;
    logic [DATA_W-1:0]  out_data_q;

    scr66_mixer #(
        .DATA_W (DATA_W),
        .STATE_W(STATE_W),
        .TAP_LO (TAP_LO),
        .TAP_HI (TAP_HI),
        .DIR    (DIR)
    ) mix_i (
        .st_in (state_q),
        .din   (in_data),
        .st_out(state_mix),
        .dout  (data_mix)
    );

    // Action select for this cycle
    always_comb begin
        if (!in_valid)   act = ACT_IDLE;
        else if (bypass) act = ACT_PASS;
        else             act = ACT_MIX;
    end

    // Shift register: advances only on a mixed block
    always_ff @(posedge clk) begin
        if (rst)                 state_q <= SEED;
        else if (act == ACT_MIX) state_q <= state_mix;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_hdr_q   <= '0;
            out_data_q  <= '0;
        end else begin
            unique case (act)
                ACT_IDLE: begin
                    out_valid_q <= 1'b0;
                end
                ACT_PASS: begin
                    out_valid_q <= 1'b1;
                    out_hdr_q   <= in_hdr;
                    out_data_q  <= in_data;
                end
                ACT_MIX: begin
                    out_valid_q <= 1'b1;
                    out_hdr_q   <= in_hdr;
                    out_data_q  <= data_mix;
                end
                default: begin
                    out_valid_q <= 1'b0;
                end
            endcase
        end
    end

    assign out_valid = out_valid_q;
    assign out_hdr   = out_hdr_q;
    assign out_data  = out_data_q;

    // ---------------- assertions ----------------
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (out_valid == $past(in_valid)));

    // R5
    hdr_align_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(in_valid)) |-> (out_hdr == $past(in_hdr)));

    // R6
    bypass_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(in_valid && bypass)) |-> (out_data == $past(in_data)));

    // R7
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!in_valid || bypass)) |-> $stable(state_q));

    generate
        if (DIR == DIR_TX) begin : g_tx_chk
            logic [STATE_W-1:0] out_tail;
            always_comb begin
                for (int k = 0; k < STATE_W; k++) out_tail[k] = out_data_q[DATA_W-1-k];
            end
            // R2
            tx_state_line_chk: assert property (@(posedge clk) disable iff (rst)
                (past_ok && $past(in_valid && !bypass)) |-> (state_q == out_tail));
        end else begin : g_rx_chk
            logic [STATE_W-1:0] in_tail;
            always_comb begin
                for (int k = 0; k < STATE_W; k++) in_tail[k] = in_data[DATA_W-1-k];
            end
            // R3
            rx_state_line_chk: assert property (@(posedge clk) disable iff (rst)
                (past_ok && $past(in_valid && !bypass)) |-> (state_q == $past(in_tail)));
        end
    endgenerate

endmodule

// File: rtl/scr66_duplex.sv
`timescale 1ns/1ps
// Transmit scrambler and receive descrambler lanes with shared bypass.
module scr66_duplex
    import scr66_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int HDR_W   = 2,
    parameter int STATE_W = 58,
    parameter int TAP_LO  = 38,
    parameter int TAP_HI  = STATE_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass_en,
    input  logic              tx_in_valid,
    input  logic [HDR_W-1:0]  tx_in_hdr,
    input  logic [DATA_W-1:0] tx_in_data,
    output logic              tx_out_valid,
    output logic [HDR_W-1:0]  tx_out_hdr,
    output logic [DATA_W-1:0] tx_out_data,
    input  logic              rx_in_valid,
    input  logic [HDR_W-1:0]  rx_in_hdr,
    input  logic [DATA_W-1:0] rx_in_data,
    output logic              rx_out_valid,
    output logic [HDR_W-1:0]  rx_out_hdr,
    output logic [DATA_W-1:0] rx_out_data
);

    scr66_lane #(
        .DATA_W(DATA_W), .HDR_W(HDR_W), .STATE_W(STATE_W),
        .TAP_LO(TAP_LO), .TAP_HI(TAP_HI), .DIR(DIR_TX)
    ) tx_lane_i (
        .clk      (clk),
        .rst      (rst),
        .bypass   (bypass_en),
        .in_valid (tx_in_valid),
        .in_hdr   (tx_in_hdr),
        .in_data  (tx_in_data),
        .out_valid(tx_out_valid),
        .out_hdr  (tx_out_hdr),
        .out_data (tx_out_data)
    );

    scr66_lane #(
        .DATA_W(DATA_W), .HDR_W(HDR_W), .STATE_W(STATE_W),
        .TAP_LO(TAP_LO), .TAP_HI(TAP_HI), .DIR(DIR_RX)
    ) rx_lane_i (
        .clk      (clk),
        .rst      (rst),
        .bypass   (bypass_en),
        .in_valid (rx_in_valid),
        .in_hdr   (rx_in_hdr),
        .in_data  (rx_in_data),
        .out_valid(rx_out_valid),
        .out_hdr  (rx_out_hdr),
        .out_data (rx_out_data)
    );

endmodule

// File: tb/scr66_duplex_tb.sv
`timescale 1ns/1ps
module scr66_duplex_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bypass_en = 1'b0;
    logic        tx_in_valid = 1'b0;
    logic [1:0]  tx_in_hdr = '0;
    logic [63:0] tx_in_data = '0;
    logic        tx_out_valid;
    logic [1:0]  tx_out_hdr;
    logic [63:0] tx_out_data;
    logic        rx_in_valid = 1'b0;
    logic [1:0]  rx_in_hdr = '0;
    logic [63:0] rx_in_data = '0;
    logic        rx_out_valid;
    logic [1:0]  rx_out_hdr;
    logic [63:0] rx_out_data;

    always #4 clk = ~clk;   // 125 MHz

    scr66_duplex dut_i (
        .clk(clk), .rst(rst), .bypass_en(bypass_en),
        .tx_in_valid(tx_in_valid), .tx_in_hdr(tx_in_hdr), .tx_in_data(tx_in_data),
        .tx_out_valid(tx_out_valid), .tx_out_hdr(tx_out_hdr), .tx_out_data(tx_out_data),
        .rx_in_valid(rx_in_valid), .rx_in_hdr(rx_in_hdr), .rx_in_data(rx_in_data),
        .rx_out_valid(rx_out_valid), .rx_out_hdr(rx_out_hdr), .rx_out_data(rx_out_data)
    );

    localparam int NVEC = 12;
    localparam logic [63:0] VEC [NVEC] = '{
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0123_4567_89AB_CDEF, 64'h5555_5555_5555_5555,
        64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_0001,
        64'h8000_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D,
        64'h1E1E_1E1E_1E1E_1E1E, 64'h0000_0000_0000_0000,
        64'hF0F0_0F0F_3C3C_C3C3, 64'h7FFF_FFFF_FFFF_FFFE
    };

    int n_chk = 0;
    int n_bad = 0;
    logic [57:0] m_tx;   // bench model register

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bit-serial model of the transmit lane
    task automatic model_scr(input logic [63:0] d, output logic [63:0] o);
        for (int i = 0; i < 64; i++) begin
            o[i] = d[i] ^ m_tx[38] ^ m_tx[57];
            m_tx = {m_tx[56:0], o[i]};
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tx_in_valid = 1'b0;
        rx_in_valid = 1'b0;
        bypass_en = 1'b0;
        tick(); tick();
        rst = 1'b0;
        m_tx = '1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] line, la, lb, lc, pa, pb, pc;
        #1;
        do_reset();
        // R1: reset state of outputs
        chk("R1 tx valid", {63'd0, tx_out_valid}, 64'd0);
        chk("R1 tx data", tx_out_data, 64'd0);
        chk("R1 rx valid", {63'd0, rx_out_valid}, 64'd0);
        chk("R1 rx data", rx_out_data, 64'd0);

        // Table walk: R1 seed, R2 scramble, R3 descramble, R4 carry, R5 header, R8 latency
        for (int v = 0; v < NVEC; v++) begin
            model_scr(VEC[v], line);
            tx_in_valid = 1'b1; tx_in_data = VEC[v]; tx_in_hdr = (v % 2 == 0) ? 2'b01 : 2'b10;
            rx_in_valid = 1'b1; rx_in_data = line;   rx_in_hdr = (v % 2 == 0) ? 2'b10 : 2'b01;
            tick();
            chk("R2 R4 tx payload", tx_out_data, line);
            chk("R3 rx payload", rx_out_data, VEC[v]);
            chk("R5 tx header", {62'd0, tx_out_hdr}, (v % 2 == 0) ? 64'd1 : 64'd2);
            chk("R5 rx header", {62'd0, rx_out_hdr}, (v % 2 == 0) ? 64'd2 : 64'd1);
            chk("R8 valid", {62'd0, tx_out_valid, rx_out_valid}, 64'd3);
            if (v % 4 == 3) begin
                // R7: idle cycle keeps register
                tx_in_valid = 1'b0; rx_in_valid = 1'b0;
                tx_in_data = ~tx_in_data; rx_in_data = ~rx_in_data;
                tick();
                chk("R7 R8 idle valid", {62'd0, tx_out_valid, rx_out_valid}, 64'd0);
            end
        end

        // R6: bypass passes payload and freezes registers
        bypass_en = 1'b1;
        tx_in_valid = 1'b1; tx_in_data = 64'hC0FF_EE00_1234_5678;
        rx_in_valid = 1'b1; rx_in_data = 64'h0F1E_2D3C_4B5A_6978;
        tick();
        chk("R6 tx bypass copy", tx_out_data, 64'hC0FF_EE00_1234_5678);
        chk("R6 rx bypass copy", rx_out_data, 64'h0F1E_2D3C_4B5A_6978);
        bypass_en = 1'b0;
        model_scr(64'h1357_9BDF_2468_ACE0, line);
        tx_in_data = 64'h1357_9BDF_2468_ACE0;
        rx_in_data = line;
        tick();
        chk("R6 tx register frozen", tx_out_data, line);
        chk("R6 rx register frozen", rx_out_data, 64'h1357_9BDF_2468_ACE0);

        // R9: self-synchronization of a mismatched receiver
        do_reset();
        pa = 64'h1111_2222_3333_4444; pb = 64'h9876_5432_10FE_DCBA; pc = 64'hA5A5_0F0F_5A5A_F0F0;
        tx_in_valid = 1'b1;
        tx_in_data = pa; tick(); la = tx_out_data;
        tx_in_data = pb; tick(); lb = tx_out_data;
        tx_in_data = pc; tick(); lc = tx_out_data;
        tx_in_valid = 1'b0;
        chk("R9 line differs from payload", {63'd0, (la == pa)}, 64'd0);
        rx_in_valid = 1'b1;
        rx_in_data = 64'hBADB_ADBA_DBAD_BADB; tick();
        rx_in_data = lb; tick();
        rx_in_data = lc; tick();
        chk("R9 rx resynchronized", rx_out_data, pc);
        rx_in_valid = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule